// File: doc/BRIEF.md
# Reset Source Tracker with Boot Remap

This block supervises system reset for a small processor subsystem. It records which event caused the most recent reset, so that boot code can read the cause back over a simple register bus. Three events leave a flag behind: power-on, watchdog expiry and a reset that software requests. A reset driven from the external pin leaves no flag, so a status that reads all zero after software has cleared it points to the pin. Flags persist until software clears them one by one through a separate write-only clear register. A power-on event resets the flags to "power-on only".

Every reset cause drives a system reset request output. That request is stretched to a fixed number of cycles after the last cycle its cause was seen. The block also holds a boot remap bit that chooses whether SRAM or flash appears at address zero, and every reset clears that bit. Two strap inputs that report reduced memory sizes can be read from the remap register.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_rst` is high and after it falls, the status register (offset 0x230) reads 0x01, the remap register (offset 0x220) reads 0x00 when both straps are low, `sram_at_zero` is 0, and `sys_rst_req` stays high for exactly PULSE_LEN (16) sampled cycles after the cycle in which `por_rst` falls.
- R2: A one-cycle `wdt_expire` pulse sets status bit 1 and leaves the other bits unchanged. It also holds `sys_rst_req` high for 16 cycles, starting with the cycle after the pulse.
- R3: A bus write to the status register with data bit 2 set sets status bit 2 and raises `sys_rst_req` for exactly 16 cycles, starting with the cycle after the write. Data bits 0, 1 and 7:3 of such a write are ignored, and a write with bit 2 clear changes nothing.
- R4: A write to the clear register (offset 0x234) clears each of status bits 2:0 whose data bit is 1 and keeps the others, so 0x07 clears all three. When a hardware set and a clear hit the same bit in the same cycle, the set wins.
- R5: While `ext_rst_pin` is high, `sys_rst_req` is high from the next cycle on, and it stays high for 16 cycles after the last cycle the pin was high. The status flags do not change.
- R6: Bit 0 of the remap register is read/write and drives `sram_at_zero`. Any reset cause (power-on, watchdog, software request, external pin) clears it at the same clock edge that starts the reset request.
- R7: Remap register bit 4 reads `strap_small_flash`, bit 3 reads `strap_small_sram`, and bits 7:5 and 2:1 read 0. Writes to those bits have no effect.
- R8: Reads of the clear register and of unmapped offsets return 0. Every bus write is ignored while `sys_rst_req` is high.
- R9: Power-on clears the watchdog and software flags. Watchdog and software resets keep flags that are already set, so the flags accumulate (0x01, then 0x03, then 0x07).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| ext_rst_pin | input | 1 | External reset request, level, active high |
| strap_small_flash | input | 1 | Strap: reduced flash size |
| strap_small_sram | input | 1 | Strap: reduced SRAM size |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| sys_rst_req | output | 1 | System reset request |
| sram_at_zero | output | 1 | 1: SRAM at address zero, 0: flash |

## Verification
A register write or a reset event is captured at the clock edge where it is presented. Read data and `sram_at_zero` are therefore correct at the next falling edge, because read data is combinational from the address. The reset request is due one edge after its cause and is then counted once per falling edge until it drops, so each reset must show exactly 16 high samples. The bench drives every stimulus on a falling edge and samples on falling edges only. It waits for the reset request to drop before any write that must take effect, and it also sends writes during the request on purpose to show that they are blocked.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    localparam int DATA_W     = 8;
    localparam int N_FLAGS    = 3;

    localparam int OFF_REMAP  = 'h220;
    localparam int OFF_STATUS = 'h230;
    localparam int OFF_CLEAR  = 'h234;

    localparam int BIT_POR    = 0;
    localparam int BIT_WDT    = 1;
    localparam int BIT_SW     = 2;
    localparam int BIT_REMAP  = 0;
    localparam int BIT_SRAM_S = 3;
    localparam int BIT_FLSH_S = 4;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic por;
    } cause_flags_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_REMAP,
        SEL_STATUS,
        SEL_CLEAR
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] pack_status(input cause_flags_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_POR] = f.por;
        v[BIT_WDT] = f.wdt;
        v[BIT_SW]  = f.sw;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_remap(input logic remap,
                                                     input logic small_sram,
                                                     input logic small_flash);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_REMAP]  = remap;
        v[BIT_SRAM_S] = small_sram;
        v[BIT_FLSH_S] = small_flash;
        return v;
    endfunction

endpackage

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
    import rst_sup_pkg::*;
(
    input  logic               clk,
    input  logic               por_rst,
    input  logic               wdt_set,
    input  logic               sw_set,
    input  logic [N_FLAGS-1:0] clr_mask,
    output cause_flags_t       flags
);

    cause_flags_t set_vec;
    cause_flags_t flags_nxt;

    always_comb begin
        set_vec     = '0;
        set_vec.wdt = wdt_set;
        set_vec.sw  = sw_set;
        // hardware set has priority over a same-cycle clear
        flags_nxt   = cause_flags_t'((flags & ~clr_mask) | set_vec);
    end

    always_ff @(posedge clk) begin
        if (por_rst) begin
            flags     <= '0;
            flags.por <= 1'b1;
        end else begin
            flags <= flags_nxt;
        end
    end

    p_wdt_sets_r2: assert property (@(posedge clk) disable iff (por_rst)
        wdt_set |=> flags.wdt);

    p_sw_sets_r3: assert property (@(posedge clk) disable iff (por_rst)
        sw_set |=> flags.sw);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_fall_chk
        p_fall_needs_clear_r4: assert property (@(posedge clk) disable iff (por_rst)
            $fell(flags[i]) |-> ($past(clr_mask[i]) || $past(por_rst)));
    end

endmodule

// File: rtl/rst_pulse_stretch.sv
module rst_pulse_stretch #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic por_rst,
    input  logic trigger,
    output logic req
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por_rst || trigger) begin
            cnt <= CNT_FULL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign req = (cnt != '0);

    p_load_full_r3: assert property (@(posedge clk) disable iff (por_rst)
        trigger |=> (cnt == CNT_FULL));

    p_no_early_drop_r3: assert property (@(posedge clk) disable iff (por_rst)
        (req && cnt != 1) |=> req);

endmodule

// File: rtl/rst_remap_ctl.sv
module rst_remap_ctl (
    input  logic clk,
    input  logic por_rst,
    input  logic trigger,
    input  logic we,
    input  logic wbit,
    output logic remap
);

    always_ff @(posedge clk) begin
        if (por_rst || trigger) begin
            remap <= 1'b0;
        end else if (we) begin
            remap <= wbit;
        end
    end

    p_remap_clr_r6: assert property (@(posedge clk) disable iff (por_rst)
        trigger |=> !remap);

    p_remap_set_r6: assert property (@(posedge clk) disable iff (por_rst)
        $rose(remap) |-> $past(we && wbit));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              wdt_expire,
    input  logic              ext_rst_pin,
    input  logic              strap_small_flash,
    input  logic              strap_small_sram,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic              sram_at_zero
);

    reg_sel_e           sel;
    logic               wr_ok;
    logic               sw_req;
    logic               remap_we;
    logic               trigger;
    logic [N_FLAGS-1:0] clr_mask;
    cause_flags_t       flags;
    logic               unused_wdata;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_REMAP))       sel = SEL_REMAP;
        else if (bus_addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
        else if (bus_addr == ADDR_W'(OFF_CLEAR))  sel = SEL_CLEAR;
        else                                      sel = SEL_NONE;
    end

    // writes are blocked while the system is held in reset
    assign wr_ok    = bus_wr && !sys_rst_req;
    assign sw_req   = wr_ok && (sel == SEL_STATUS) && bus_wdata[BIT_SW];
    assign remap_we = wr_ok && (sel == SEL_REMAP);
    assign clr_mask = (wr_ok && sel == SEL_CLEAR) ? bus_wdata[N_FLAGS-1:0] : '0;
    assign trigger  = wdt_expire || sw_req || ext_rst_pin;
    assign unused_wdata = ^bus_wdata[DATA_W-1:N_FLAGS];

    rst_cause_flags u_flags (
        .clk      (clk),
        .por_rst  (por_rst),
        .wdt_set  (wdt_expire),
        .sw_set   (sw_req),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    rst_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
        .clk     (clk),
        .por_rst (por_rst),
        .trigger (trigger),
        .req     (sys_rst_req)
    );

    rst_remap_ctl u_remap (
        .clk     (clk),
        .por_rst (por_rst),
        .trigger (trigger),
        .we      (remap_we),
        .wbit    (bus_wdata[BIT_REMAP]),
        .remap   (sram_at_zero)
    );

    always_comb begin
        unique case (sel)
            SEL_REMAP:  bus_rdata = pack_remap(sram_at_zero, strap_small_sram, strap_small_flash);
            SEL_STATUS: bus_rdata = pack_status(flags);
            default:    bus_rdata = '0;
        endcase
    end

    p_ext_hold_r5: assert property (@(posedge clk) disable iff (por_rst)
        ext_rst_pin |=> sys_rst_req);

    p_remap_low_in_reset_r8: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst_req |-> !sram_at_zero);

    p_ext_no_flag_r5: assert property (@(posedge clk) disable iff (por_rst)
        (ext_rst_pin && !wdt_expire && !sw_req && clr_mask == '0) |=> $stable(flags));

endmodule

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;

    localparam logic [11:0] A_REMAP  = 12'h220;
    localparam logic [11:0] A_STATUS = 12'h230;
    localparam logic [11:0] A_CLEAR  = 12'h234;
    localparam int          LEN      = 16;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        wdt_expire = 1'b0;
    logic        ext_rst_pin = 1'b0;
    logic        strap_small_flash = 1'b0;
    logic        strap_small_sram = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        sys_rst_req;
    logic        sram_at_zero;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rst_supervisor dut (
        .clk(clk), .por_rst(por_rst), .wdt_expire(wdt_expire), .ext_rst_pin(ext_rst_pin),
        .strap_small_flash(strap_small_flash), .strap_small_sram(strap_small_sram),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req), .sram_at_zero(sram_at_zero)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic req_len(output int n);
        n = 0;
        while (sys_rst_req && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_por();
        por_rst = 1'b1;
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
    endtask

    task automatic wdt_pulse();
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int n;

        // R1: power-on state
        @(negedge clk);
        do_por();
        rd(A_STATUS, d); chk("R1 status after por", d, 8'h01);
        rd(A_REMAP, d);  chk("R1 remap after por", d, 8'h00);
        chk("R1 sram_at_zero after por", sram_at_zero, 0);
        req_len(n);      chk("R1 request length after por", n, LEN);

        // R7: strap read-back, all four combinations
        for (int s = 0; s < 4; s++) begin
            strap_small_sram = s[0]; strap_small_flash = s[1];
            rd(A_REMAP, d);
            chk("R7 strap bits", d, (s[1] << 4) | (s[0] << 3));
        end
        strap_small_sram = 1'b0; strap_small_flash = 1'b0;

        // R6/R7: full sweep of remap write data
        for (int v = 0; v < 256; v++) begin
            wr(A_REMAP, 8'(v));
            rd(A_REMAP, d);
            chk("R7 remap read after write", d, v & 1);
            chk("R6 sram_at_zero follows bit 0", sram_at_zero, v & 1);
        end

        // R6/R2: watchdog clears remap, sets bit 1, holds request
        wr(A_REMAP, 8'h01);
        chk("R6 remap set", sram_at_zero, 1);
        wdt_pulse();
        chk("R6 remap cleared by watchdog", sram_at_zero, 0);
        req_len(n); chk("R2 request length after watchdog", n, LEN);
        rd(A_STATUS, d); chk("R2/R9 status after watchdog", d, 8'h03);

        // R3: software reset; R8: writes blocked while busy
        wr(A_REMAP, 8'h01);
        wr(A_STATUS, 8'h04);
        chk("R6 remap cleared by software reset", sram_at_zero, 0);
        wr(A_REMAP, 8'h01);
        wr(A_CLEAR, 8'h07);
        req_len(n); chk("R3 request length after software write", n + 2, LEN);
        rd(A_STATUS, d); chk("R8/R9 status kept, clear blocked during reset", d, 8'h07);
        rd(A_REMAP, d);  chk("R8 remap write blocked during reset", d, 8'h00);

        // R3: exact request length with nothing written during it
        wr(A_STATUS, 8'h04);
        req_len(n); chk("R3 request length exact", n, LEN);

        // R8: clear register and unmapped offsets read zero
        rd(A_CLEAR, d);  chk("R8 clear reg reads zero", d, 0);
        rd(12'h100, d);  chk("R8 unmapped offset reads zero", d, 0);
        rd(12'h224, d);  chk("R8 unmapped offset near remap reads zero", d, 0);

        // R9: power-on from 0x07 gives 0x01
        do_por(); req_len(n);
        rd(A_STATUS, d); chk("R9 por resets flags", d, 8'h01);

        // R4: sweep of clear masks over a full status
        for (int v = 0; v < 8; v++) begin
            do_por(); req_len(n);
            wdt_pulse(); req_len(n);
            wr(A_STATUS, 8'h04); req_len(n);
            rd(A_STATUS, d); chk("R9 accumulated flags", d, 8'h07);
            wr(A_CLEAR, 8'(v) | 8'hF8);
            rd(A_STATUS, d); chk("R4 clear mask", d, 7 & ~v);
        end

        // R3: write to status without bit 2 changes nothing
        rd(A_STATUS, d); chk("R4 all flags cleared", d, 8'h00);
        wr(A_STATUS, 8'hFB);
        chk("R3 no request without bit 2", sys_rst_req, 0);
        rd(A_STATUS, d); chk("R3 other status bits ignored", d, 8'h00);

        // R5: external pin: request, no flag
        wr(A_REMAP, 8'h01);
        ext_rst_pin = 1'b1;
        @(negedge clk);
        chk("R5 request while pin high", sys_rst_req, 1);
        chk("R6 remap cleared by pin", sram_at_zero, 0);
        repeat (3) @(negedge clk);
        ext_rst_pin = 1'b0;
        req_len(n); chk("R5 request length after pin", n, LEN);
        rd(A_STATUS, d); chk("R5 status zero after external reset", d, 8'h00);

        // R4: same-cycle set and clear, set wins
        wdt_expire = 1'b1;
        wr(A_CLEAR, 8'h02);
        wdt_expire = 1'b0;
        req_len(n);
        rd(A_STATUS, d); chk("R4 set wins over clear", d, 8'h02);

        finish_run();
    end

endmodule